// File: doc/BRIEF.md
# Coherent Two-Byte Position Snapshot Reader

This block keeps a snapshot register of a running position count and hands it to a narrow host bus as two 8-bit bytes. While the host is not reading, the snapshot follows the counter on every rising clock edge. When the host starts a read by selecting the upper byte, the snapshot is frozen. It stays frozen until the lower byte has been read and the host has let go of the bus. Both bytes of one read therefore describe the same instant, even if the counter keeps moving or carries across the byte boundary between the two accesses.

The read-enable and byte-select pins are sampled on the falling clock edge by a small control machine. Its state decides whether the next rising edge may load the snapshot. The output port is modelled as a tri-state driver: an 8-bit data value plus a drive-enable flag. A build-time parameter narrows the snapshot to 12 bits. In that build, the four top bits of the upper byte always read as zero.

Top module: `posLatchReadout`

## Requirements
- R1: While the active-low reset `rstN` is low, the snapshot is held at zero, so both byte selections read 0x00.
- R2: `dataOe` is 1 exactly when `oeN` is 0, and 0 when `oeN` is 1 (bus released to high impedance); it follows `oeN` without a clock.
- R3: While no read sequence is in progress, the snapshot loads the counter on every rising edge. Sampling `oeN` = 0 with `selLow` = 1 (lower-byte read alone) does not freeze it.
- R4: When a falling edge samples `oeN` = 0 with `selLow` = 0 (upper-byte read), later rising edges no longer load the snapshot, so counter changes are not visible.
- R5: `selLow` = 0 presents snapshot bits 15..8 on `dataOut`, and `selLow` = 1 presents bits 7..0.
- R6: A frozen snapshot is released only after a falling edge has sampled `oeN` = 0 with `selLow` = 1 and a later falling edge has sampled `oeN` = 1. Loading resumes at the next rising edge. Raising `oeN` before the lower byte has been read keeps the freeze.
- R7: With `VALID_BITS` = 12, the snapshot holds counter bits 11..0, and bits 7..4 of the upper byte read as zero.
- R8: Asserting `rstN` in the middle of a frozen read clears the snapshot at once. After release, the block is back in the tracking state without needing a lower-byte read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; snapshot loads on rising edge, control samples on falling edge |
| rstN | input | 1 | Asynchronous active-low reset |
| posCount | input | COUNT_W (16) | Live position count to be snapshotted |
| oeN | input | 1 | Active-low read enable / bus drive enable |
| selLow | input | 1 | Byte select: 0 = upper byte, 1 = lower byte |
| dataOut | output | BYTE_W (8) | Selected byte of the snapshot |
| dataOe | output | 1 | Drive enable for `dataOut`; 0 means high impedance |

## Verification
The main function is tried with a normal upper-then-lower read while the counter jumps to an unrelated value between the bytes; this separates a frozen snapshot from one that keeps tracking. A lower-byte read on its own shows that only an upper-byte access starts a freeze. A read where the bus is released before the lower byte, and a read where the enable is held low after the lower byte, each show that release needs both conditions in order. A reset in the middle of a freeze and a 12-bit build with all ones in the counter's top nibble separate clearing from holding and zero-fill from pass-through.

// File: rtl/posrd_pkg.sv
package posrd_pkg;

  // Control machine state, advanced on the falling clock edge
  typedef enum logic [1:0] {
    RD_IDLE    = 2'd0,  // snapshot tracks the counter
    RD_HOLD    = 2'd1,  // upper byte requested, snapshot frozen
    RD_LOWSEEN = 2'd2   // lower byte read, waiting for bus release
  } rdState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadEn;    // snapshot may load on the next rising edge
    logic showLow;   // present the lower byte
    logic driveBus;  // output drivers enabled
  } rdStrobe_t;

endpackage

// File: rtl/posrdCtrl.sv
module posrdCtrl
  import posrd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      oeN,
  input  logic      selLow,
  output rdStrobe_t strobe
);

  rdState_t state;
  rdState_t nextState;
  logic     loadEn;

  wire upperRead = !oeN && !selLow;
  wire lowerRead = !oeN &&  selLow;

  always_comb begin
    nextState = state;
    unique case (state)
      RD_IDLE: begin
        if (upperRead) nextState = RD_HOLD;
      end
      RD_HOLD: begin
        if (lowerRead) nextState = RD_LOWSEEN;
      end
      RD_LOWSEEN: begin
        if (oeN)            nextState = RD_IDLE;
        else if (upperRead) nextState = RD_HOLD;
      end
      default: nextState = RD_IDLE;
    endcase
  end

  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) state <= RD_IDLE;
    else       state <= nextState;
  end

  assign loadEn          = (state == RD_IDLE);
  assign strobe.loadEn   = loadEn;
  assign strobe.showLow  = selLow;
  assign strobe.driveBus = !oeN;

  // R6
  inhibit_release_chk: assert property (@(negedge clk) disable iff (!rstN)
    $rose(loadEn) |-> $past(oeN));

  // R4
  inhibit_set_chk: assert property (@(negedge clk) disable iff (!rstN)
    $fell(loadEn) |-> (!$past(oeN) && !$past(selLow)));

endmodule

// File: rtl/posrdPath.sv
module posrdPath
  import posrd_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int COUNT_W    = 16,
  parameter int VALID_BITS = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [VALID_BITS-1:0] cntIn,
  input  rdStrobe_t             strobe,
  output logic [BYTE_W-1:0]     dataOut,
  output logic                  dataOe
);

  logic [VALID_BITS-1:0] latchQ;
  logic [COUNT_W-1:0]    latchExt;
  logic [BYTE_W-1:0]     hiByte;
  logic [BYTE_W-1:0]     loByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              latchQ <= '0;
    else if (strobe.loadEn) latchQ <= cntIn;
  end

  generate
    if (VALID_BITS < COUNT_W) begin : g_zeroFill
      assign latchExt = {{(COUNT_W - VALID_BITS){1'b0}}, latchQ};
    end else begin : g_fullWidth
      assign latchExt = latchQ;
    end
  endgenerate

  assign hiByte  = latchExt[COUNT_W-1 -: BYTE_W];
  assign loByte  = latchExt[BYTE_W-1:0];
  assign dataOut = strobe.showLow ? loByte : hiByte;
  assign dataOe  = strobe.driveBus;

  // R4
  latch_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadEn |=> $stable(latchQ));

  // R3
  latch_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadEn |=> (latchQ == $past(cntIn)));

endmodule

// File: rtl/posLatchReadout.sv
module posLatchReadout
  import posrd_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int COUNT_W    = 2 * BYTE_W,
  parameter int VALID_BITS = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [COUNT_W-1:0] posCount,
  input  logic               oeN,
  input  logic               selLow,
  output logic [BYTE_W-1:0]  dataOut,
  output logic               dataOe
);

  rdStrobe_t strobe;

  posrdCtrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .oeN    (oeN),
    .selLow (selLow),
    .strobe (strobe)
  );

  posrdPath #(
    .BYTE_W     (BYTE_W),
    .COUNT_W    (COUNT_W),
    .VALID_BITS (VALID_BITS)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .cntIn   (posCount[VALID_BITS-1:0]),
    .strobe  (strobe),
    .dataOut (dataOut),
    .dataOe  (dataOe)
  );

endmodule

// File: tb/posLatchReadout_tb.sv
module posLatchReadout_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] posCount = 16'hFFFF;
  logic        oeN = 1'b0;
  logic        selLow = 1'b0;
  logic [7:0]  dataOut;
  logic        dataOe;
  logic [7:0]  dataOut12;
  logic        dataOe12;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  posLatchReadout u_dut (
    .clk(clk), .rstN(rstN), .posCount(posCount), .oeN(oeN),
    .selLow(selLow), .dataOut(dataOut), .dataOe(dataOe)
  );

  posLatchReadout #(.VALID_BITS(12)) u_dut12 (
    .clk(clk), .rstN(rstN), .posCount(posCount), .oeN(oeN),
    .selLow(selLow), .dataOut(dataOut12), .dataOe(dataOe12)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic testResetState();
    repeat (2) tick();
    #3;
    chk("R1 upper byte in reset", dataOut, 8'h00);
    selLow = 1'b1;
    #1;
    chk("R1 lower byte in reset", dataOut, 8'h00);
    chk("R2 dataOe with oeN low", {7'd0, dataOe}, 8'h01);
    oeN = 1'b1;
    #1;
    chk("R2 dataOe with oeN high", {7'd0, dataOe}, 8'h00);
    selLow = 1'b0;
    tick();
    rstN = 1'b1;
    tick();
  endtask

  task automatic testIdleTrack();
    oeN = 1'b1; selLow = 1'b1; posCount = 16'h0F1E;
    tick();
    oeN = 1'b0;
    #3;
    chk("R3 tracked lower byte", dataOut, 8'h1E);
    posCount = 16'h7788;
    tick(); #3;
    chk("R3 lower read alone keeps tracking", dataOut, 8'h88);
    oeN = 1'b1; selLow = 1'b0;
    tick();
  endtask

  task automatic testCoherentRead();
    oeN = 1'b1; posCount = 16'hA5C3;
    tick(); tick();
    oeN = 1'b0; selLow = 1'b0; posCount = 16'h1234;
    #3;
    chk("R5 upper byte bits 15..8", dataOut, 8'hA5);
    tick();
    selLow = 1'b1;
    #3;
    chk("R4 lower byte from frozen snapshot", dataOut, 8'hC3);
    tick();
    oeN = 1'b1; posCount = 16'h5678;
    tick();
    oeN = 1'b0;
    #3;
    chk("R6 loading resumed after release", dataOut, 8'h78);
    oeN = 1'b1; selLow = 1'b0;
    tick();
  endtask

  task automatic testHoldWithoutLow();
    oeN = 1'b1; posCount = 16'h1357;
    tick(); tick();
    oeN = 1'b0; selLow = 1'b0; posCount = 16'hACE0;
    tick();
    oeN = 1'b1;
    tick(); tick();
    oeN = 1'b0; selLow = 1'b1;
    #3;
    chk("R6 freeze kept when bus released before lower read", dataOut, 8'h57);
    tick();
    oeN = 1'b1;
    tick();
    oeN = 1'b0; selLow = 1'b0;
    #3;
    chk("R6 new value after proper release", dataOut, 8'hAC);
    tick();
    selLow = 1'b1;
    tick();
    oeN = 1'b1;
    tick(); tick();
  endtask

  task automatic testReleaseWait();
    oeN = 1'b1; posCount = 16'h2468;
    tick(); tick();
    oeN = 1'b0; selLow = 1'b0; posCount = 16'h9999;
    tick();
    selLow = 1'b1;
    tick(); tick(); tick();
    #3;
    chk("R6 still frozen while oeN held low", dataOut, 8'h68);
    selLow = 1'b0;
    #1;
    chk("R4 upper byte still frozen", dataOut, 8'h24);
    selLow = 1'b1;
    oeN = 1'b1;
    tick(); tick();
  endtask

  task automatic testResetMidFreeze();
    oeN = 1'b1; posCount = 16'hBEEF;
    tick(); tick();
    oeN = 1'b0; selLow = 1'b0;
    #3;
    chk("R5 upper byte before reset", dataOut, 8'hBE);
    tick();
    rstN = 1'b0;
    #1;
    chk("R8 reset clears frozen upper byte", dataOut, 8'h00);
    selLow = 1'b1;
    #1;
    chk("R8 reset clears frozen lower byte", dataOut, 8'h00);
    oeN = 1'b1; selLow = 1'b0; posCount = 16'hCAFE;
    tick();
    rstN = 1'b1;
    tick();
    oeN = 1'b0; selLow = 1'b1;
    #3;
    chk("R8 tracking after reset without lower read", dataOut, 8'hFE);
    oeN = 1'b1; selLow = 1'b0;
    tick();
  endtask

  task automatic testTwelveBit();
    oeN = 1'b1; posCount = 16'hFABC;
    tick(); tick();
    oeN = 1'b0; selLow = 1'b0;
    #3;
    chk("R7 12-bit upper byte zero-filled", dataOut12, 8'h0A);
    chk("R5 16-bit upper byte", dataOut, 8'hFA);
    selLow = 1'b1;
    #1;
    chk("R7 12-bit lower byte", dataOut12, 8'hBC);
    chk("R2 dataOe on 12-bit build", {7'd0, dataOe12}, 8'h01);
    oeN = 1'b1; selLow = 1'b0;
    tick();
  endtask

  initial begin
    testResetState();
    testIdleTrack();
    testCoherentRead();
    testHoldWithoutLow();
    testReleaseWait();
    testResetMidFreeze();
    testTwelveBit();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule